// File: doc/BRIEF.md
# Bypass Buffer with Spatial Reuse Detection

This block is a small set-associative store that sits beside the first-level data cache and keeps data that was fetched without being placed in that cache. Each line is one 8-byte element, and the buffer holds 128 of them in 32 sets of 4 ways. A lookup presents a byte address and gets back a hit flag and the element one cycle later. A fill writes one element per cycle. A whole 32-byte cache line arrives as four consecutive element fills, and each fill states whether it carries the element that the processor actually asked for.

Alongside the data, every line keeps two flags. The first says whether the line was the one that started the fetch. The second says whether reuse of a neighbouring element has been seen. From these flags the block emits single-cycle pulses that raise or lower a per-macroblock spatial counter held elsewhere. A macroblock is 1 KiB. That counter later decides whether a bypass fetch brings in one element or a full line.

Top module: `bypass_spatial_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lk_hit`, `inc_pulse` and `dec_pulse` are 0.
- R2: A lookup returns its result on the clock edge after it is presented. `lk_hit` is 1 and `lk_data` equals the last data filled for that 8-byte element (address bits above bit 2) when the element is held. Otherwise `lk_hit` is 0. With no lookup, `lk_hit` and `inc_pulse` are 0.
- R3: A lookup that misses while another element of the same 32-byte line (address bits above bit 4 equal) is held raises `inc_pulse` for one cycle, with `inc_mb` = lookup address bits [ADDR_W-1:10]. A miss with no such element raises no pulse.
- R4: After a miss that raised `inc_pulse`, the next fill of that element with `fill_init`=1 marks it as spatially reused.
- R5: A hit to an element filled with `fill_init`=0 marks it as spatially reused. A hit to an element filled with `fill_init`=1 does not.
- R6: A fill that evicts a valid element raises `dec_pulse` for one cycle when no held element of the evicted element's 32-byte line is marked as reused. `dec_mb` is then the evicted address bits [ADDR_W-1:10]. A newly allocated element starts unmarked unless R4 applies.
- R7: Within a set, a fill takes the lowest-numbered empty way, or else the least recently used way. Both hits and fills count as uses.
- R8: A lookup and a fill in the same cycle are resolved fill first. A lookup of the element being filled hits with the fill data, and the line being filled counts as a neighbour for R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Lookup byte address |
| fill_valid | input | 1 | Element fill this cycle |
| fill_addr | input | ADDR_W | Fill byte address |
| fill_data | input | DATA_W | Fill element data |
| fill_init | input | 1 | This fill carries the demand-missing element |
| lk_hit | output | 1 | Registered lookup hit |
| lk_data | output | DATA_W | Registered lookup data |
| inc_pulse | output | 1 | Raise spatial counter of `inc_mb` |
| inc_mb | output | ADDR_W-10 | Macroblock number for the increment |
| dec_pulse | output | 1 | Lower spatial counter of `dec_mb` |
| dec_mb | output | ADDR_W-10 | Macroblock number for the decrement |

## Verification
The bench runs the sequences where the flag logic is easiest to get wrong. One case evicts a line whose neighbour inherited its reuse mark from an earlier sibling-detected miss. A design that drops that mark would emit a spurious decrement. Other cases hit the initiator and a non-initiator of a whole-line fill: a design that ignores the initiator flag either marks everything or nothing, and the decrement on eviction shows which. Further cases drive a lookup and a fill together, where a design that reads the old state misses the forwarded element or the fill-supplied neighbour. A hit placed between fills checks that the replacement choice follows recency, since picking the wrong victim turns a later hit into a miss.

// File: rtl/bypass_spatial_buf.sv
module bypass_spatial_buf #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int WAYS       = 4,
  parameter int SETS       = 32,
  parameter int ELEM_BYTES = 8,
  parameter int LINE_ELEMS = 4,
  parameter int MB_BYTES   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_init,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              inc_pulse,
  output logic [ADDR_W-$clog2(MB_BYTES)-1:0] inc_mb,
  output logic              dec_pulse,
  output logic [ADDR_W-$clog2(MB_BYTES)-1:0] dec_mb
);
  localparam int OFF_W = $clog2(ELEM_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LE_W  = $clog2(LINE_ELEMS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int EL_W  = ADDR_W - OFF_W;
  localparam int LN_W  = EL_W - LE_W;
  localparam int MB_W  = ADDR_W - $clog2(MB_BYTES);

  logic [WAYS-1:0]   v_q  [SETS];
  logic [WAYS-1:0]   sr_q [SETS];
  logic [WAYS-1:0]   fi_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];
  logic [WAY_W-1:0]  age_q [SETS][WAYS];

  logic              pend_v, pend_sr;
  logic [EL_W-1:0]   pend_el;

  wire [SET_W-1:0] lk_set  = lk_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  wire [LN_W-1:0]  lk_line = lk_addr[ADDR_W-1 -: LN_W];
  wire [SET_W-1:0] fl_set  = fill_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] fl_tag  = fill_addr[ADDR_W-1 -: TAG_W];
  wire [LN_W-1:0]  fl_line = fill_addr[ADDR_W-1 -: LN_W];
  wire [EL_W-1:0]  fl_el   = fill_addr[ADDR_W-1 -: EL_W];
  wire [EL_W-1:0]  lk_el   = lk_addr[ADDR_W-1 -: EL_W];

  logic unused_lo;
  assign unused_lo = ^{lk_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  logic             fl_hit, have_inv;
  logic [WAY_W-1:0] fl_hit_way, inv_way, old_way, fl_way;
  always_comb begin
    fl_hit = 1'b0; fl_hit_way = '0; have_inv = 1'b0; inv_way = '0; old_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (v_q[fl_set][w] && tag_q[fl_set][w] == fl_tag) begin
        fl_hit = 1'b1; fl_hit_way = WAY_W'(w);
      end
    for (int w = WAYS-1; w >= 0; w--)
      if (!v_q[fl_set][w]) begin
        have_inv = 1'b1; inv_way = WAY_W'(w);
      end
    for (int w = 0; w < WAYS; w++)
      if (age_q[fl_set][w] == WAY_W'(WAYS-1)) old_way = WAY_W'(w);
  end

  assign fl_way = fl_hit ? fl_hit_way : (have_inv ? inv_way : old_way);
  wire              evict   = fill_valid && !fl_hit && !have_inv;
  wire [TAG_W-1:0]  vic_tag = tag_q[fl_set][fl_way];
  wire [ADDR_W-1:0] vic_addr = {vic_tag, fl_set, {OFF_W{1'b0}}};
  wire              sr_init = pend_v && pend_sr && fill_init && pend_el == fl_el;

  logic raw_hit, sib, vic_sr;
  logic [WAY_W-1:0] raw_way;
  always_comb begin
    raw_hit = 1'b0; raw_way = '0; sib = 1'b0; vic_sr = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (v_q[lk_set][w] && tag_q[lk_set][w] == lk_tag &&
          !(evict && fl_set == lk_set && fl_way == WAY_W'(w))) begin
        raw_hit = 1'b1; raw_way = WAY_W'(w);
      end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        if (v_q[s][w] && tag_q[s][w] == lk_tag &&
            (s >> LE_W) == int'(lk_set >> LE_W) &&
            !(evict && s == int'(fl_set) && w == int'(fl_way)))
          sib = 1'b1;
        if (v_q[s][w] && sr_q[s][w] && tag_q[s][w] == vic_tag &&
            (s >> LE_W) == int'(fl_set >> LE_W))
          vic_sr = 1'b1;
      end
    if (fill_valid && fl_line == lk_line) sib = 1'b1;
  end

  wire              fwd     = fill_valid && fl_el == lk_el;
  wire              hit     = fwd || raw_hit;
  wire [WAY_W-1:0]  hit_way = fwd ? fl_way : raw_way;
  wire              hit_fi  = fwd ? fill_init : fi_q[lk_set][raw_way];
  wire [DATA_W-1:0] hit_dat = fwd ? fill_data : dat_q[lk_set][raw_way];
  wire              lk_use  = lk_valid && hit && !(fill_valid && fl_set == lk_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0; sr_q[s] <= '0; fi_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0; dat_q[s][w] <= '0; age_q[s][w] <= WAY_W'(w);
        end
      end
      pend_v <= 1'b0; pend_sr <= 1'b0; pend_el <= '0;
      lk_hit <= 1'b0; lk_data <= '0;
      inc_pulse <= 1'b0; inc_mb <= '0;
      dec_pulse <= 1'b0; dec_mb <= '0;
    end else begin
      if (fill_valid) begin
        v_q[fl_set][fl_way]   <= 1'b1;
        tag_q[fl_set][fl_way] <= fl_tag;
        dat_q[fl_set][fl_way] <= fill_data;
        fi_q[fl_set][fl_way]  <= fill_init;
        sr_q[fl_set][fl_way]  <= fl_hit ? sr_q[fl_set][fl_way] : sr_init;
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == fl_way) age_q[fl_set][w] <= '0;
          else if (age_q[fl_set][w] < age_q[fl_set][fl_way])
            age_q[fl_set][w] <= age_q[fl_set][w] + 1'b1;
        if (fill_init && pend_el == fl_el) pend_v <= 1'b0;
      end
      if (lk_valid && hit && !hit_fi) sr_q[lk_set][hit_way] <= 1'b1;
      if (lk_use)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == hit_way) age_q[lk_set][w] <= '0;
          else if (age_q[lk_set][w] < age_q[lk_set][hit_way])
            age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
      if (lk_valid && !hit) begin
        pend_v <= 1'b1; pend_sr <= sib; pend_el <= lk_el;
      end
      lk_hit    <= lk_valid && hit;
      lk_data   <= (lk_valid && hit) ? hit_dat : '0;
      inc_pulse <= lk_valid && !hit && sib;
      if (lk_valid && !hit && sib) inc_mb <= lk_addr[ADDR_W-1 -: MB_W];
      dec_pulse <= evict && !vic_sr;
      if (evict && !vic_sr) dec_mb <= vic_addr[ADDR_W-1 -: MB_W];
    end
  end
endmodule

// File: rtl/bsb_checker.sv
module bsb_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int ELEM_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [DATA_W-1:0] fill_data,
  input logic              lk_hit,
  input logic [DATA_W-1:0] lk_data,
  input logic              inc_pulse,
  input logic              dec_pulse
);
  localparam int OFF_W = $clog2(ELEM_BYTES);

  AST_HIT_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid)); // R2
  AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && !inc_pulse)); // R2
  AST_INC_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pulse |-> (!lk_hit && $past(lk_valid))); // R3
  AST_DEC_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pulse |-> $past(fill_valid)); // R6
  AST_FILL_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fill_valid && lk_addr[ADDR_W-1:OFF_W] == fill_addr[ADDR_W-1:OFF_W])
      |=> (lk_hit && lk_data == $past(fill_data))); // R8
endmodule

bind bypass_spatial_buf bsb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_BYTES(ELEM_BYTES)
) u_bsb_chk (.*);

// File: tb/test_bypass_spatial_buf.sv
module test_bypass_spatial_buf;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int MW = AW - 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0, fill_init = 1'b0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic lk_hit, inc_pulse, dec_pulse;
  logic [DW-1:0] lk_data;
  logic [MW-1:0] inc_mb, dec_mb;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bypass_spatial_buf i_bypass_spatial_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_init(fill_init), .lk_hit(lk_hit), .lk_data(lk_data),
    .inc_pulse(inc_pulse), .inc_mb(inc_mb), .dec_pulse(dec_pulse), .dec_mb(dec_mb));

  typedef struct {
    logic hit; logic [DW-1:0] data; logic inc; logic dec; logic [MW-1:0] mb; string req;
  } exp_t;
  exp_t sb[$];

  function automatic logic [DW-1:0] dat(logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic cyc(input logic lv, input logic [AW-1:0] la, input logic fv,
                     input logic [AW-1:0] fa, input logic fi, input logic eh,
                     input logic einc, input logic edec, input logic [MW-1:0] emb,
                     input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; fill_valid = fv; fill_addr = fa;
    fill_data = dat(fa); fill_init = fi;
    e.hit = eh; e.data = dat(la); e.inc = einc; e.dec = edec; e.mb = emb; e.req = req;
    sb.push_back(e);
  endtask

  task automatic look(input logic [AW-1:0] a, input logic eh, input logic einc,
                      input logic [MW-1:0] emb, input string req);
    cyc(1'b1, a, 1'b0, '0, 1'b0, eh, einc, 1'b0, emb, req);
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic fi, input logic edec,
                      input logic [MW-1:0] emb, input string req);
    cyc(1'b0, '0, 1'b1, a, fi, 1'b0, 1'b0, edec, emb, req);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (lk_hit !== e.hit || (e.hit && lk_data !== e.data) ||
          inc_pulse !== e.inc || (e.inc && inc_mb !== e.mb) ||
          dec_pulse !== e.dec || (e.dec && dec_mb !== e.mb)) begin
        errors++;
        $display("FAIL %s: got hit=%0b data=%h inc=%0b/%h dec=%0b/%h, expected hit=%0b data=%h inc=%0b dec=%0b mb=%h",
                 e.req, lk_hit, lk_data, inc_pulse, inc_mb, dec_pulse, dec_mb,
                 e.hit, e.data, e.inc, e.dec, e.mb);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    checks++;
    if (lk_hit !== 1'b0 || inc_pulse !== 1'b0 || dec_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: got hit=%0b inc=%0b dec=%0b, expected 0 0 0", lk_hit, inc_pulse, dec_pulse);
    end
    look(32'h1000, 0, 0, '0, "R2 cold miss, R3 no sibling");
    fill(32'h1000, 1, 0, '0, "R6 fill into empty way");
    look(32'h1000, 1, 0, '0, "R2 hit after fill");
    look(32'h1008, 0, 1, 22'h4, "R3 sibling present");
    fill(32'h1008, 1, 0, '0, "R4 fill marked element");
    look(32'h1008, 1, 0, '0, "R2 hit second element");
    fill(32'h5100, 1, 0, '0, "R7 empty way");
    fill(32'h6200, 1, 0, '0, "R7 empty way");
    fill(32'h7300, 1, 0, '0, "R7 empty way");
    fill(32'h8400, 1, 0, '0, "R4 evict with reused sibling, no decrement");
    look(32'h1000, 0, 1, 22'h4, "R7 evicted element misses, R3 sibling");
    fill(32'h2000, 1, 1, 22'h14, "R6 decrement for unmarked line");
    look(32'h3028, 0, 0, '0, "R3 miss without sibling");
    fill(32'h3020, 0, 0, '0, "R5 line fill");
    fill(32'h3028, 1, 0, '0, "R5 line fill initiator");
    fill(32'h3030, 0, 0, '0, "R5 line fill");
    fill(32'h3038, 0, 0, '0, "R5 line fill");
    look(32'h3028, 1, 0, '0, "R5 hit initiator");
    look(32'h3030, 1, 0, '0, "R5 hit non-initiator");
    fill(32'h3120, 1, 0, '0, "R7 empty way");
    fill(32'h3220, 1, 0, '0, "R7 empty way");
    fill(32'h3320, 1, 0, '0, "R7 empty way");
    fill(32'h3420, 1, 0, '0, "R5 non-initiator hit marked line");
    fill(32'h4040, 1, 0, '0, "R5 single element");
    look(32'h4040, 1, 0, '0, "R5 hit initiator only");
    fill(32'h4140, 1, 0, '0, "R7 empty way");
    fill(32'h4240, 1, 0, '0, "R7 empty way");
    fill(32'h4340, 1, 0, '0, "R7 empty way");
    fill(32'h4440, 1, 1, 22'h10, "R5 initiator hit leaves line unmarked");
    cyc(1, 32'h9008, 1, 32'h9008, 1, 1, 0, 0, '0, "R8 forward fill data");
    cyc(1, 32'h9010, 1, 32'h9018, 1, 0, 1, 0, 22'h24, "R8 fill counts as sibling");
    fill(32'hA060, 1, 0, '0, "R7 empty way");
    fill(32'hA160, 1, 0, '0, "R7 empty way");
    fill(32'hA260, 1, 0, '0, "R7 empty way");
    fill(32'hA360, 1, 0, '0, "R7 empty way");
    look(32'hA060, 1, 0, '0, "R7 refresh oldest");
    fill(32'hA460, 1, 1, 22'h28, "R7 evict least recent");
    look(32'hA060, 1, 0, '0, "R7 refreshed element kept");
    look(32'hA160, 0, 0, '0, "R7 least recent gone");
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule